// File: doc/BRIEF.md
# PC-Relative Branch Target Unit

This block resolves the destination of the short relative jump family in a small CPU with a 16-bit program address space. For every branch request it receives the address of the branch instruction, a 3-bit operation code, an 8-bit signed operand, the carry and zero flags, and the state of an extension prefix. It answers with the next program counter, an indication of whether the jump was taken, and a pulse that tells the flag logic to clear the extension prefix.

The displacement is always counted from the instruction that follows the branch. Without the prefix, the operand is sign-extended, which gives a reach of -128 to +127. With the prefix set, an 8-bit extension register forms the high byte and the operand forms the low byte of a signed 16-bit displacement. That form reaches anywhere in the 64K space. The result is registered, so it appears one clock after the request. Fetch, decode, calls, returns and the stack stay outside the block.

Top module: `pcrel_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `res_valid`, `res_taken`, `res_ext_clear` and `res_next_pc` (all zero) at that edge.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. `res_taken` and `res_ext_clear` are low whenever `res_valid` is low.
- R3: With `req_ext_mode` = 0, a taken jump yields `req_pc + 1 + sign_extend(req_disp)`, which gives a reach of -128 to +127 from the following instruction.
- R4: With `req_ext_mode` = 1, a taken jump yields `req_pc + 1 + D`. D is the signed 16-bit value whose high byte is `req_ext_byte` and whose low byte is `req_disp`. For example, an extension byte of 100 with an operand of 100 lands 25701 addresses after the branch.
- R5: The operation codes on `req_op` are: 0 = always jump, 1 = jump when C = 1, 2 = jump when C = 0, 3 = jump when Z = 1, 4 = jump when Z = 0. Only the named flag affects the outcome.
- R6: A branch that is not taken yields `req_pc + 1` on `res_next_pc`.
- R7: For codes 0 to 4 with `req_ext_mode` = 1, `res_ext_clear` is high with the result, whether or not the jump is taken. With `req_ext_mode` = 0 it stays low.
- R8: Codes 5, 6 and 7 are not branches. They give `res_taken` = 0, `res_ext_clear` = 0 and `res_next_pc` = `req_pc + 1`.
- R9: All address arithmetic wraps modulo 65536. This covers the sequential address after 0xFFFF and targets below 0 or above 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A branch request is presented this cycle |
| req_op | input | 3 | Branch operation code (see R5, R8) |
| req_pc | input | 16 | Address of the branch instruction |
| req_disp | input | 8 | Signed displacement operand, low byte |
| req_flag_c | input | 1 | Carry flag |
| req_flag_z | input | 1 | Zero flag |
| req_ext_mode | input | 1 | Extension prefix is active |
| req_ext_byte | input | 8 | Extension register, high displacement byte |
| res_valid | output | 1 | Result fields are valid |
| res_next_pc | output | 16 | Address of the next instruction to fetch |
| res_taken | output | 1 | The jump was taken |
| res_ext_clear | output | 1 | Clear the extension prefix |

## Verification
The displacement path is tested in both modes at the edges of its range: -128, -1, 0 and +127 in short mode, and -32768, -1, +25700 and +32767 in extended mode. A wrong sign extension, a dropped high byte or an offset counted from the branch itself would each give a distinct wrong target at these points. Every operation code is applied under all four carry/zero combinations. This separates the polarity of each condition and exposes any condition that looks at the wrong flag. Addresses near 0x0000 and 0xFFFF show that the sum wraps. The reserved codes, and requests made with the prefix on and off, show when the clear pulse should and should not appear.

// File: rtl/pcrel_pkg.sv
// Package: pcrel_pkg
// Shared widths and operation codes for the relative branch unit.
// Assumes a machine where each branch instruction occupies one address step.
package pcrel_pkg;

    localparam int unsigned ADDR_W_DEF = 16;
    localparam int unsigned DISP_W_DEF = 8;
    localparam int unsigned OP_W       = 3;

    // Operation codes decoded by the condition evaluator.
    localparam logic [OP_W-1:0] OP_ALWAYS = 3'd0;
    localparam logic [OP_W-1:0] OP_IF_C   = 3'd1;
    localparam logic [OP_W-1:0] OP_IF_NC  = 3'd2;
    localparam logic [OP_W-1:0] OP_IF_Z   = 3'd3;
    localparam logic [OP_W-1:0] OP_IF_NZ  = 3'd4;

    // Registered result of one branch request.
    typedef struct packed {
        logic                  valid;
        logic                  taken;
        logic                  ext_clear;
        logic [ADDR_W_DEF-1:0] next_pc;
    } br_result_t;

endpackage

// File: rtl/pcrel_disp_sel.sv
// Module: pcrel_disp_sel
// Builds the full-width signed displacement. It either sign-extends the
// short operand, or, in extension mode, places the extension byte above
// the operand and sign-extends the combined value.
// Assumes ADDR_W >= 2*DISP_W.
module pcrel_disp_sel #(
    parameter int unsigned DISP_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic [DISP_W-1:0] disp_lo,
    input  logic [DISP_W-1:0] ext_hi,
    input  logic              ext_mode,
    output logic [ADDR_W-1:0] disp_full
);
    localparam int unsigned LONG_W    = 2 * DISP_W;
    localparam int unsigned SHORT_PAD = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] long_ext;
    logic [LONG_W-1:0] long_raw;

    // Concatenate the extension byte above the operand.
    always_comb long_raw = {ext_hi, disp_lo};

    // Sign-extend the short operand to the address width.
    always_comb short_ext = {{SHORT_PAD{disp_lo[DISP_W-1]}}, disp_lo};

    generate
        if (ADDR_W > LONG_W) begin : g_long_pad
            localparam int unsigned LONG_PAD = ADDR_W - LONG_W;
            // Sign-extend the combined displacement to the address width.
            always_comb long_ext = {{LONG_PAD{long_raw[LONG_W-1]}}, long_raw};
        end else begin : g_long_exact
            // The combined displacement already fills the address width.
            always_comb long_ext = long_raw[ADDR_W-1:0];
        end
    endgenerate

    // Choose between the short and extended displacement.
    always_comb disp_full = ext_mode ? long_ext : short_ext;

endmodule

// File: rtl/pcrel_cond_eval.sv
// Module: pcrel_cond_eval
// Decodes the operation code. Reports whether the code names a branch,
// and whether that branch is taken under the current carry and zero flags.
// Codes outside the branch set are reported as non-branches.
module pcrel_cond_eval
    import pcrel_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            flag_c,
    input  logic            flag_z,
    output logic            is_branch,
    output logic            take
);
    // Evaluate the jump condition for each operation code.
    always_comb begin
        is_branch = 1'b1;
        take      = 1'b0;
        case (op)
            OP_ALWAYS: take = 1'b1;
            OP_IF_C:   take = flag_c;
            OP_IF_NC:  take = ~flag_c;
            OP_IF_Z:   take = flag_z;
            OP_IF_NZ:  take = ~flag_z;
            default: begin
                is_branch = 1'b0;
                take      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcrel_target_add.sv
// Module: pcrel_target_add
// Forms the sequential address (branch address plus one instruction step)
// and the jump target (sequential address plus displacement).
// Both wrap modulo 2**ADDR_W.
module pcrel_target_add #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned INSTR_STEP = 1
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] disp_full,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] tgt_pc
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(INSTR_STEP);

    // Address of the instruction that follows the branch.
    always_comb seq_pc = cur_pc + STEP_V;

    // Jump target, measured from the following instruction.
    always_comb tgt_pc = seq_pc + disp_full;

endmodule

// File: rtl/pcrel_branch_unit.sv
// Module: pcrel_branch_unit
// Top of the relative branch resolver. It combines the displacement,
// condition and adder stages, then registers the result one clock after
// the request. The extension prefix is consumed by every real branch,
// whether or not the jump is taken.
// Assumes a synchronous active-low reset and one request per cycle at most.
module pcrel_branch_unit
    import pcrel_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned DISP_W     = DISP_W_DEF,
    parameter int unsigned INSTR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_flag_c,
    input  logic              req_flag_z,
    input  logic              req_ext_mode,
    input  logic [DISP_W-1:0] req_ext_byte,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_next_pc,
    output logic              res_taken,
    output logic              res_ext_clear
);
    localparam int unsigned SHORT_PAD = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_full;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;
    logic              is_branch;
    logic              take;
    logic [ADDR_W-1:0] nxt_pc_d;
    logic              taken_d;
    logic              clear_d;

    pcrel_disp_sel #(
        .DISP_W    (DISP_W),
        .ADDR_W    (ADDR_W)
    ) disp_i (
        .disp_lo   (req_disp),
        .ext_hi    (req_ext_byte),
        .ext_mode  (req_ext_mode),
        .disp_full (disp_full)
    );

    pcrel_cond_eval cond_i (
        .op        (req_op),
        .flag_c    (req_flag_c),
        .flag_z    (req_flag_z),
        .is_branch (is_branch),
        .take      (take)
    );

    pcrel_target_add #(
        .ADDR_W     (ADDR_W),
        .INSTR_STEP (INSTR_STEP)
    ) add_i (
        .cur_pc    (req_pc),
        .disp_full (disp_full),
        .seq_pc    (seq_pc),
        .tgt_pc    (tgt_pc)
    );

    // Pick the next address and qualify the flags with the request.
    always_comb begin
        taken_d  = req_valid & is_branch & take;
        clear_d  = req_valid & is_branch & req_ext_mode;
        nxt_pc_d = taken_d ? tgt_pc : seq_pc;
    end

    // Register the result; the address holds while no request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_taken     <= 1'b0;
            res_ext_clear <= 1'b0;
            res_next_pc   <= '0;
        end else begin
            res_valid     <= req_valid;
            res_taken     <= taken_d;
            res_ext_clear <= clear_d;
            if (req_valid) begin
                res_next_pc <= nxt_pc_d;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                       // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_taken && !res_ext_clear));   // R2
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_ALWAYS) |=> res_taken);              // R5
    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |->
        res_next_pc == ADDR_W'($past(req_pc) + ADDR_W'(INSTR_STEP)));   // R6
    AST_SHORT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && !$past(req_ext_mode)) |->
        res_next_pc == ADDR_W'($past(req_pc) + ADDR_W'(INSTR_STEP)
            + {{SHORT_PAD{$past(req_disp[DISP_W-1])}}, $past(req_disp)})); // R3
    AST_EXT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ext_mode && req_op <= OP_IF_NZ) |=> res_ext_clear); // R7
    AST_NO_CLEAR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext_mode) |=> !res_ext_clear);               // R7
    AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > OP_IF_NZ) |=> (!res_taken && !res_ext_clear)); // R8

endmodule

// File: tb/pcrel_branch_unit_tb_top.sv
// Directed bench for pcrel_branch_unit: one task per scenario, each with its own checks.
module pcrel_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [15:0] req_pc;
    logic [7:0]  req_disp;
    logic        req_flag_c;
    logic        req_flag_z;
    logic        req_ext_mode;
    logic [7:0]  req_ext_byte;
    logic        res_valid;
    logic [15:0] res_next_pc;
    logic        res_taken;
    logic        res_ext_clear;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pcrel_branch_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_pc        (req_pc),
        .req_disp      (req_disp),
        .req_flag_c    (req_flag_c),
        .req_flag_z    (req_flag_z),
        .req_ext_mode  (req_ext_mode),
        .req_ext_byte  (req_ext_byte),
        .res_valid     (res_valid),
        .res_next_pc   (res_next_pc),
        .res_taken     (res_taken),
        .res_ext_clear (res_ext_clear)
    );

    // One check; prints a FAIL line on mismatch.
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference condition from the code table in R5 and R8.
    function automatic bit ref_take(input logic [2:0] op, input bit c, input bit z);
        case (op)
            3'd0: return 1'b1;
            3'd1: return c;
            3'd2: return !c;
            3'd3: return z;
            3'd4: return !z;
            default: return 1'b0;
        endcase
    endfunction

    // Drive one request at a falling edge and check the result one clock later.
    task automatic branch(input string req, input logic [2:0] op, input logic [15:0] pc,
                          input logic [7:0] d, input bit c, input bit z, input bit ext,
                          input logic [7:0] eb);
        logic [15:0] disp;
        logic [15:0] exp_pc;
        bit          tk;
        bit          isb;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_pc = pc; req_disp = d;
        req_flag_c = c; req_flag_z = z; req_ext_mode = ext; req_ext_byte = eb;
        @(negedge clk);
        req_valid = 1'b0;
        isb  = (op <= 3'd4);
        tk   = ref_take(op, c, z);
        disp = ext ? {eb, d} : {{8{d[7]}}, d};
        exp_pc = tk ? 16'(pc + 16'd1 + disp) : 16'(pc + 16'd1);
        chk(req, "valid",     {31'd0, res_valid}, 32'd1);
        chk(req, "next_pc",   {16'd0, res_next_pc}, {16'd0, exp_pc});
        chk(req, "taken",     {31'd0, res_taken}, {31'd0, tk});
        chk(req, "ext_clear", {31'd0, res_ext_clear}, {31'd0, (isb && ext)});
    endtask

    // R1: outputs clear while reset is held.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "valid",     {31'd0, res_valid}, 32'd0);
        chk("R1", "taken",     {31'd0, res_taken}, 32'd0);
        chk("R1", "ext_clear", {31'd0, res_ext_clear}, 32'd0);
        chk("R1", "next_pc",   {16'd0, res_next_pc}, 32'd0);
        rst_n = 1'b1;
    endtask

    // R3: short displacements at the edges of the 8-bit range.
    task automatic t_short_bounds();
        branch("R3", 3'd0, 16'h4000, 8'h80, 0, 0, 0, 8'h55);  // -128
        branch("R3", 3'd0, 16'h4000, 8'h7F, 0, 0, 0, 8'h55);  // +127
        branch("R3", 3'd0, 16'h4000, 8'hFF, 1, 1, 0, 8'h00);  // -1: lands on the branch
        branch("R3", 3'd0, 16'h1234, 8'h00, 0, 1, 0, 8'hFF);  // 0: next instruction
    endtask

    // R4: extended displacements, including the 100/100 example.
    task automatic t_ext_bounds();
        branch("R4", 3'd0, 16'h8000, 8'h00, 0, 0, 1, 8'h80);  // -32768
        branch("R4", 3'd0, 16'h0000, 8'hFF, 0, 0, 1, 8'h7F);  // +32767
        branch("R4", 3'd0, 16'h2000, 8'hFF, 0, 0, 1, 8'hFF);  // -1
        branch("R4", 3'd0, 16'h0100, 8'd100, 0, 0, 1, 8'd100);
        chk("R4", "25701 steps", {16'd0, res_next_pc}, 32'h0100 + 32'd25701);
    endtask

    // R5/R6/R7: every branch code under every flag pair, prefix on and off.
    task automatic t_conditions();
        for (int op = 0; op < 5; op++) begin
            for (int f = 0; f < 4; f++) begin
                branch("R5", 3'(op), 16'h3000, 8'h10, f[0], f[1], 0, 8'h00);
                branch("R6", 3'(op), 16'h3000, 8'hF0, f[0], f[1], 1, 8'h01);
            end
        end
        branch("R7", 3'd1, 16'h0500, 8'h05, 0, 0, 1, 8'h02);   // not taken, still consumes
    endtask

    // R8: reserved codes are inert even with flags and prefix set.
    task automatic t_reserved();
        for (int op = 5; op < 8; op++) begin
            branch("R8", 3'(op), 16'h0777, 8'h40, 1, 1, 1, 8'h10);
            branch("R8", 3'(op), 16'hFFFF, 8'h40, 0, 0, 0, 8'h10);
        end
    endtask

    // R9: wrap of the sequential address and of the target.
    task automatic t_wrap();
        branch("R9", 3'd2, 16'hFFFF, 8'h10, 1, 0, 0, 8'h00);  // not taken, 0xFFFF+1 -> 0
        branch("R9", 3'd0, 16'hFFF0, 8'h7F, 0, 0, 0, 8'h00);  // past the top
        branch("R9", 3'd0, 16'h0002, 8'h80, 0, 0, 0, 8'h00);  // below zero
        branch("R9", 3'd0, 16'hF000, 8'hFF, 0, 0, 1, 8'h7F);  // extended past the top
    endtask

    // R2: no request gives a quiet result one clock later.
    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0; req_ext_mode = 1'b1;
        @(negedge clk);
        chk("R2", "idle valid",     {31'd0, res_valid}, 32'd0);
        chk("R2", "idle taken",     {31'd0, res_taken}, 32'd0);
        chk("R2", "idle ext_clear", {31'd0, res_ext_clear}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        req_valid = 1'b0; req_op = '0; req_pc = '0; req_disp = '0;
        req_flag_c = 1'b0; req_flag_z = 1'b0; req_ext_mode = 1'b0; req_ext_byte = '0;
        rst_n = 1'b0;
        t_reset();
        t_idle();
        t_short_bounds();
        t_ext_bounds();
        t_conditions();
        t_reserved();
        t_wrap();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule